// File: doc/BRIEF.md
# Banked Synchronous Word Memory

This block is a word-addressed synchronous memory assembled from four identical sub-RAMs rather than from one flat array. Each sub-RAM carries its own select, shares the write/read control, the low address bits and the write data with its siblings, and keeps a private registered read port. A two-to-four decoder on the top two address bits enables exactly one sub-RAM per access. A multiplexer steered by the registered bank index then merges the four read ports onto the single output.

The requester raises `sel_i` to start an access. With `wen_i` high it writes `wdata_i` at the rising edge. With `wen_i` low it reads, and the word appears on `rdata_o` one cycle later. While `sel_i` is low nothing happens inside the memory. `OFFS_W` sets the depth of each sub-RAM and `DATA_W` sets the word width. The compiled defaults are small (256 x 8 per bank, 1 K x 8 in all). Setting `OFFS_W = 16` gives four 64 K x 8 banks, which form 256 K x 8 on 18 address lines.

Top module: `banked_sram`

## Requirements
- R1: After reset, `rdata_o` is zero until the first read completes.
- R2: While `sel_i` is 0, no word is stored and `rdata_o` keeps its value, whatever `wen_i`, `addr_i` and `wdata_i` are.
- R3: With `sel_i` = 1 and `wen_i` = 1, `wdata_i` is stored at `addr_i` on the rising clock edge, and a later read of that address returns it.
- R4: With `sel_i` = 1 and `wen_i` = 0, the word stored at `addr_i` appears on `rdata_o` in the cycle after the edge that accepts the read, so back-to-back reads return one word per cycle.
- R5: During a read, `wdata_i` has no effect on any stored word.
- R6: `rdata_o` holds the last read word through write cycles and idle cycles.
- R7: `addr_i` is split into a bank index (its two most significant bits) and an offset (the remaining `OFFS_W` bits). Index 0 holds the lowest quarter of the address space and index 3 holds the highest, so every one of the 2^(`OFFS_W`+2) addresses is a separate word.
- R8: A write to one bank leaves the word at the same offset in every other bank unchanged.
- R9: During an access, exactly one sub-RAM select is active. When `sel_i` is 0, no sub-RAM select is active.
- R10: The address width is `OFFS_W` + 2 bits. With the defaults, this is 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all storage and read registers update on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the read path |
| sel_i | input | 1 | Access enable; 0 means no operation |
| wen_i | input | 1 | 1 = write, 0 = read, valid while `sel_i` is 1 |
| addr_i | input | OFFS_W+2 | Word address: bank index in the top two bits, offset below |
| wdata_i | input | DATA_W | Word to store on a write |
| rdata_o | output | DATA_W | Word returned by the most recent read |

## Verification
A write is due at the first rising edge after its inputs are driven. A read result is due one register stage later, because the sub-RAM output register and the bank-index register both load on the same edge and the merge is combinational. The bench drives each operation just after a falling edge and holds it for exactly one clock. It samples `rdata_o` at the next falling edge, halfway between the accepting edge and the following one. Hold checks for idle and write cycles sample at the same point and compare against the value returned by the preceding read.

// File: rtl/banked_sram_pkg.sv
package banked_sram_pkg;
    // Number of sub-RAMs and the address bits that index them
    localparam int NUM_BANKS = 4;
    localparam int BANK_BITS = $clog2(NUM_BANKS);
endpackage

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int OFFS_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              wen_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << OFFS_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Write port: commits on the clock edge when this bank is chosen
    always_ff @(posedge clk_i) begin
        if (cs_i && wen_i) begin
            store_q[offs_i] <= wdata_i;
        end
    end

    // Registered read port: loads only on a read to this bank, else holds
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else if (cs_i && !wen_i) begin
            rd_q <= store_q[offs_i];
        end
    end

    assign rdata_o = rd_q;

    // R6: the bank read register is untouched by anything but a read
    a_r6_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cs_i && !wen_i) |=> $stable(rdata_o));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import banked_sram_pkg::*;
(
    input  logic                 en_i,
    input  logic [BANK_BITS-1:0] idx_i,
    output logic [NUM_BANKS-1:0] cs_o
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
        assign cs_o[g] = en_i && (idx_i == BANK_BITS'(g));
    end

    // R9: one select at most, and one exactly when enabled
    always_comb begin
        a_r9_dec_onehot: assert ($onehot0(cs_o));
    end
endmodule

// File: rtl/bank_merge.sv
module bank_merge
    import banked_sram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data_i,
    input  logic [BANK_BITS-1:0]             idx_i,
    output logic [DATA_W-1:0]                data_o
);
    always_comb begin
        data_o = bank_data_i[idx_i];
    end
endmodule

// File: rtl/banked_sram.sv
module banked_sram
    import banked_sram_pkg::*;
#(
    parameter int OFFS_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        sel_i,
    input  logic                        wen_i,
    input  logic [OFFS_W+BANK_BITS-1:0] addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o
);
    localparam int ADDR_W = OFFS_W + BANK_BITS;

    logic [BANK_BITS-1:0]             bank_idx;
    logic [OFFS_W-1:0]                offs;
    logic [NUM_BANKS-1:0]             bank_cs;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
    logic [BANK_BITS-1:0]             rd_bank_q;

    assign bank_idx = addr_i[ADDR_W-1 -: BANK_BITS];
    assign offs     = addr_i[OFFS_W-1:0];

    bank_decoder u_dec (
        .en_i  (sel_i),
        .idx_i (bank_idx),
        .cs_o  (bank_cs)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sram_bank #(
            .OFFS_W (OFFS_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cs_i    (bank_cs[b]),
            .wen_i   (wen_i),
            .offs_i  (offs),
            .wdata_i (wdata_i),
            .rdata_o (bank_rd[b])
        );
    end

    // Bank index of the last read, steering the output merge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_bank_q <= '0;
        end else if (sel_i && !wen_i) begin
            rd_bank_q <= bank_idx;
        end
    end

    bank_merge #(.DATA_W(DATA_W)) u_merge (
        .bank_data_i (bank_rd),
        .idx_i       (rd_bank_q),
        .data_o      (rdata_o)
    );

    // R9: an access enables exactly one sub-RAM
    a_r9_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |-> $countones(bank_cs) == 1);
    // R2: no sub-RAM is enabled while the block is deselected
    a_r2_no_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |-> bank_cs == '0);
    // R2: a deselected cycle leaves the output alone
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> $stable(rdata_o));
    // R6: a write cycle leaves the output alone
    a_r6_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wen_i) |=> $stable(rdata_o));
endmodule

// File: tb/banked_sram_tb_top.sv
module banked_sram_tb_top;
    localparam int OFFS_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = OFFS_W + 2;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int BANK_WORDS = 1 << OFFS_W;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              sel_i = 1'b0;
    logic              wen_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] rdata_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [DATA_W-1:0] model [WORDS];
    logic [DATA_W-1:0] got;

    always #4 clk_i = ~clk_i;

    banked_sram #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) dut_i (
        .clk_i, .rst_ni, .sel_i, .wen_i, .addr_i, .wdata_i, .rdata_o
    );

    function automatic logic [DATA_W-1:0] pat(int a);
        return DATA_W'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Each operation is driven after a falling edge and lasts one clock
    task automatic op(logic s, logic w, int a, logic [DATA_W-1:0] d);
        sel_i = s; wen_i = w; addr_i = ADDR_W'(a); wdata_i = d;
        @(negedge clk_i);
        sel_i = 1'b0; wen_i = 1'b0;
    endtask

    task automatic wr(int a, logic [DATA_W-1:0] d);
        op(1'b1, 1'b1, a, d);
        model[a] = d;
    endtask

    task automatic rd(int a, string req);
        op(1'b1, 1'b0, a, ~model[a]);
        check(req, rdata_o, model[a]);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 reset output", rdata_o, '0);
        tests++;
        if ($bits(addr_i) != 10) begin
            fails++;
            $display("FAIL R10: actual %0d expected 10", $bits(addr_i));
        end

        // R3 / R7: fill every word, then read all back (R4 one-cycle latency)
        for (int a = 0; a < WORDS; a++) wr(a, pat(a));
        for (int a = 0; a < WORDS; a++) rd(a, "R4 R7 sweep read");
        // R4: back-to-back reads hopping across banks
        for (int a = 0; a < 16; a++) rd((a * 67 + (a % 4) * BANK_WORDS) % WORDS, "R4 interleaved");

        // R6: hold through write and idle cycles
        rd(300, "R4 before hold");
        wr(301, 8'h5a);
        check("R6 hold after write", rdata_o, model[300]);
        op(1'b0, 1'b0, 12, 8'h00);
        check("R6 hold after idle", rdata_o, model[300]);

        // R2: deselected write attempt must not store and must not move output
        op(1'b0, 1'b1, 5, ~model[5]);
        check("R2 output unchanged", rdata_o, model[300]);
        rd(5, "R2 no store");

        // R5: write data during read is ignored
        op(1'b1, 1'b0, 7, 8'haa);
        check("R5 read ignores data", rdata_o, model[7]);
        rd(7, "R5 word unchanged");

        // R8: first and last word of each bank, cross-bank isolation
        for (int b = 0; b < 4; b++) begin
            wr(b * BANK_WORDS, DATA_W'(8'hc0 | b));
            wr(b * BANK_WORDS + BANK_WORDS - 1, DATA_W'(8'h30 | b));
            for (int o = 0; o < 4; o++) begin
                rd(o * BANK_WORDS, "R8 first word");
                rd(o * BANK_WORDS + BANK_WORDS - 1, "R8 last word");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule